// File: doc/BRIEF.md
# Boot Command Sequencer

This block runs the early boot command exchange over a mailbox. A host loads a command frame into the mailbox 0 RAM and a front end raises `cmd_ready` for one cycle with the frame length. Frames are packed against the top of the window, so a frame of length L fills window offsets `WIN_BYTES - L` up to `WIN_BYTES - 1`. The sequencer reads the 32-bit command word from the lowest four bytes of the frame, least significant byte first, and decodes it. When a command produces a reply, the reply is written back through the same RAM port so that it too ends on the last byte of the window.

Completion is signalled through a credit pair and not through a status flag. The pair is a counter, loaded with the reply length, and a decrement mirror, set to all ones. The host polls these to learn how many reply bytes are waiting. The "done" command closes the boot phase for good. The target identification command replies in a short 4-byte format or an extended 16-byte format, and a parameter chooses between the two.

Top module: `boot_cmd_seq`

## Requirements
- R1: A `cmd_ready` pulse is accepted when the block is idle, boot is not done and `cmd_len` is at least 4. `busy` is high from the next cycle until the cycle after the credit update, and low otherwise.
- R2: The command word is the four bytes at offsets `WIN_BYTES - cmd_len` to `WIN_BYTES - cmd_len + 3`. The byte at the lowest offset is bits 7:0.
- R3: A frame of length 0 to 3 gives a one-cycle `err_short` pulse. It causes no RAM access and no credit change, and `busy` stays low.
- R4: Codes 0, 2–7 and 9–12 write nothing to the RAM, load the credit counter with 0 and set the mirror to 0xFF.
- R5: Code 1 sets `boot_done`, loads the counter with 0 and sets the mirror to 0xFF. `boot_done` never clears before reset, and while it is set `cmd_ready` is ignored.
- R6: With `EXT_RESP = 0`, code 8 writes bytes 0x44, 0x00, 0x00, 0x11 to offsets `WIN_BYTES-4` through `WIN_BYTES-1`, loads the counter with 4 and sets the mirror to 0xFF.
- R7: With `EXT_RESP = 1`, code 8 writes four little-endian words from offset `WIN_BYTES-16` upward: 0xFFFFFFFF, 0x0000000C, 0x11000044, 0x00000001. It loads the counter with 16 and sets the mirror to 0xFF.
- R8: A code above 12 gives a one-cycle `err_bad_cmd` pulse and leaves the counter and mirror unchanged. Nothing is written to the RAM.
- R9: `mbox_wr` clears both the counter and the mirror to 0 while boot is not done. After boot is done it has no effect.
- R10: After reset the counter is 0, the mirror is 0xFF, and `busy`, `boot_done` and both error outputs are low.
- R11: There is at most one RAM access per cycle. Read data is taken one cycle after `mem_rd_en`. Reply bytes are written one per cycle at rising addresses, all inside the top `RESP_BYTES` of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_ready | input | 1 | One-cycle pulse: a complete frame sits in the mailbox |
| cmd_len | input | AW+1 | Frame length in bytes |
| mbox_wr | input | 1 | Front end wrote a byte to mailbox 0 |
| mem_addr | output | AW | Mailbox RAM address |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_rd_data | input | 8 | RAM read data, one cycle after the strobe |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wr_data | output | 8 | RAM write data |
| busy | output | 1 | Command in progress |
| boot_done | output | 1 | Boot phase closed |
| err_short | output | 1 | Pulse: frame shorter than 4 bytes |
| err_bad_cmd | output | 1 | Pulse: unknown command code |
| credit_cnt | output | CW | Reply length counter |
| credit_dec | output | CW | Decrement mirror |

## Verification
The bound checker watches several properties on every cycle. It checks that an accepted pulse raises `busy`, that a short frame raises the error and stays idle, and that a ready pulse after boot is done is ignored. It also checks that `boot_done` is sticky, that the RAM port never reads and writes in the same cycle, that reply writes run at rising addresses inside the top of the window, and that the credit pair changes only on a clear or at the end of a command. Some results only the directed scenarios can show: the decoded command word with its byte order and frame offset, the exact reply bytes in both formats, and the values loaded into the counter and mirror.

// File: rtl/boot_cmd_pkg.sv
// Package: shared states and constants of the boot command sequencer.
// Assumes command codes are compared as full 32-bit words.
package boot_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_REPLY,
        ST_CREDIT
    } bcs_state_e;

    localparam logic [31:0] CODE_NOP       = 32'd0;
    localparam logic [31:0] CODE_FINISH    = 32'd1;
    localparam logic [31:0] CODE_IDENT    = 32'd8;
    localparam logic [31:0] CODE_MAX_KNOWN = 32'd12;

    localparam logic [31:0] IDENT_VERSION  = 32'h1100_0044;
    localparam logic [31:0] IDENT_MARKER   = 32'hFFFF_FFFF;
    localparam logic [31:0] IDENT_INFO_LEN = 32'h0000_000C;
    localparam logic [31:0] IDENT_KIND     = 32'h0000_0001;

endpackage

// File: rtl/bcs_word_fetch.sv
// Module: reads four consecutive RAM bytes from a base address and
// assembles them little-endian. Assumes one-cycle RAM read latency and
// that start only arrives while no fetch is running.
module bcs_word_fetch #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic [31:0]   word,
    output logic          done
);

    logic          issuing;
    logic [1:0]    idx;
    logic [AW-1:0] base_q;
    logic          cap_v;
    logic [1:0]    ncap;
    logic          done_q;

    // Issue four reads, then shift returning bytes in from the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            idx     <= '0;
            base_q  <= '0;
            cap_v   <= 1'b0;
            ncap    <= '0;
            word    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            cap_v  <= issuing;
            if (start) begin
                issuing <= 1'b1;
                idx     <= '0;
                base_q  <= base;
                ncap    <= '0;
            end else if (issuing) begin
                idx <= idx + 2'd1;
                if (idx == 2'd3) issuing <= 1'b0;
            end
            if (cap_v) begin
                word <= {rd_data, word[31:8]};
                ncap <= ncap + 2'd1;
                if (ncap == 2'd3) done_q <= 1'b1;
            end
        end
    end

    assign rd_en   = issuing;
    assign rd_addr = base_q + AW'(idx);
    assign done    = done_q;

endmodule

// File: rtl/bcs_reply_store.sv
// Module: writes a reply of len bytes so that its last byte lands on the
// top byte of the window, lowest byte first, one byte per cycle.
// Assumes len <= MAX_BYTES and start only while idle.
module bcs_reply_store #(
    parameter int AW        = 11,
    parameter int WIN_BYTES = 2048,
    parameter int MAX_BYTES = 16,
    localparam int LW       = $clog2(MAX_BYTES + 1),
    localparam int SW       = AW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LW-1:0]          len,
    input  logic [MAX_BYTES*8-1:0] payload,
    output logic                   wr_en,
    output logic [AW-1:0]          wr_addr,
    output logic [7:0]             wr_data,
    output logic                   done
);

    logic          active;
    logic [LW-1:0] idx;
    logic [LW-1:0] len_q;
    logic          done_q;
    logic [SW-1:0] addr_full;

    // Step through the reply bytes and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                idx   <= '0;
                len_q <= len;
                if (len == '0) done_q <= 1'b1;
                else           active <= 1'b1;
            end else if (active) begin
                idx <= idx + LW'(1);
                if (idx == len_q - LW'(1)) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Address is top of window minus reply length plus byte index.
    always_comb begin
        addr_full = SW'(WIN_BYTES) - SW'(len_q) + SW'(idx);
        wr_addr   = addr_full[AW-1:0];
        wr_data   = payload[32'(idx)*8 +: 8];
    end

    assign wr_en = active;
    assign done  = done_q;

endmodule

// File: rtl/bcs_credit_reg.sv
// Module: reply credit counter and its decrement mirror.
// Assumes a load and a clear in the same cycle resolve to the load.
module bcs_credit_reg #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] dec
);

    // Hold the credit pair; load wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dec <= '1;
        end else if (load) begin
            cnt <= load_val;
            dec <= '1;
        end else if (clear) begin
            cnt <= '0;
            dec <= '0;
        end
    end

endmodule

// File: rtl/boot_cmd_seq.sv
// Module: top of the boot command sequencer. Fetches the command word of a
// top-aligned frame, decodes it, stores any reply top-aligned and then
// loads the credit pair. Assumes cmd_ready only pulses while a full frame
// sits in the RAM and that cmd_len does not exceed WIN_BYTES.
module boot_cmd_seq
    import boot_cmd_pkg::*;
#(
    parameter int WIN_BYTES = 2048,
    parameter bit EXT_RESP  = 1'b0,
    parameter int CW        = 8,
    localparam int AW       = $clog2(WIN_BYTES),
    localparam int LENW     = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_ready,
    input  logic [LENW-1:0] cmd_len,
    input  logic            mbox_wr,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd_en,
    input  logic [7:0]      mem_rd_data,
    output logic            mem_wr_en,
    output logic [7:0]      mem_wr_data,
    output logic            busy,
    output logic            boot_done,
    output logic            err_short,
    output logic            err_bad_cmd,
    output logic [CW-1:0]   credit_cnt,
    output logic [CW-1:0]   credit_dec
);

    localparam int MAXB       = 16;
    localparam int RLW        = $clog2(MAXB + 1);
    localparam int RESP_BYTES = EXT_RESP ? 16 : 4;

    bcs_state_e        state;
    logic [RLW-1:0]    rlen_q;
    logic              take_cmd;
    logic              take_short;
    logic [LENW-1:0]   base_full;
    logic              rd_en_w;
    logic [AW-1:0]     rd_addr_w;
    logic [31:0]       cmd_word;
    logic              fetch_done;
    logic              store_start;
    logic [RLW-1:0]    store_len;
    logic [MAXB*8-1:0] reply_bits;
    logic              wr_en_w;
    logic [AW-1:0]     wr_addr_w;
    logic [7:0]        wr_data_w;
    logic              store_done;

    // Classify an incoming ready pulse and locate the frame start.
    always_comb begin
        take_cmd   = (state == ST_IDLE) && cmd_ready && !boot_done && (cmd_len >= LENW'(4));
        take_short = (state == ST_IDLE) && cmd_ready && !boot_done && (cmd_len <  LENW'(4));
        base_full  = LENW'(WIN_BYTES) - cmd_len;
    end

    // Choose the identification reply layout from the format parameter.
    generate
        if (EXT_RESP) begin : g_ext
            assign reply_bits = {IDENT_KIND, IDENT_VERSION, IDENT_INFO_LEN, IDENT_MARKER};
        end else begin : g_short
            assign reply_bits = {96'd0, IDENT_VERSION};
        end
    endgenerate

    // Reply length chosen at decode; only identification replies.
    always_comb begin
        store_start = (state == ST_DECODE) && (cmd_word <= CODE_MAX_KNOWN);
        store_len   = (cmd_word == CODE_IDENT) ? RLW'(RESP_BYTES) : '0;
    end

    // Command sequencing state machine with error pulses and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            rlen_q      <= '0;
            boot_done   <= 1'b0;
            err_short   <= 1'b0;
            err_bad_cmd <= 1'b0;
        end else begin
            err_short   <= take_short;
            err_bad_cmd <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take_cmd) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (fetch_done) state <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (cmd_word > CODE_MAX_KNOWN) begin
                        err_bad_cmd <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        rlen_q <= store_len;
                        if (cmd_word == CODE_FINISH) boot_done <= 1'b1;
                        state <= ST_REPLY;
                    end
                end
                ST_REPLY: begin
                    if (store_done) state <= ST_CREDIT;
                end
                ST_CREDIT: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    bcs_word_fetch #(.AW(AW)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (take_cmd),
        .base    (base_full[AW-1:0]),
        .rd_en   (rd_en_w),
        .rd_addr (rd_addr_w),
        .rd_data (mem_rd_data),
        .word    (cmd_word),
        .done    (fetch_done)
    );

    bcs_reply_store #(.AW(AW), .WIN_BYTES(WIN_BYTES), .MAX_BYTES(MAXB)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (store_start),
        .len     (store_len),
        .payload (reply_bits),
        .wr_en   (wr_en_w),
        .wr_addr (wr_addr_w),
        .wr_data (wr_data_w),
        .done    (store_done)
    );

    bcs_credit_reg #(.CW(CW)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (mbox_wr && !boot_done),
        .load     (state == ST_CREDIT),
        .load_val (CW'(rlen_q)),
        .cnt      (credit_cnt),
        .dec      (credit_dec)
    );

    // Share the single RAM port between fetch and reply phases.
    always_comb begin
        mem_rd_en   = rd_en_w;
        mem_wr_en   = wr_en_w;
        mem_wr_data = wr_data_w;
        mem_addr    = wr_en_w ? wr_addr_w : rd_addr_w;
        busy        = (state != ST_IDLE);
    end

endmodule

// File: rtl/boot_cmd_seq_chk.sv
// Module: cycle-level checker for boot_cmd_seq, attached with bind.
// Assumes it sees only the top-level ports.
module boot_cmd_seq_chk #(
    parameter int WIN_BYTES = 2048,
    parameter bit EXT_RESP  = 1'b0,
    parameter int CW        = 8,
    localparam int AW       = $clog2(WIN_BYTES),
    localparam int LENW     = AW + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_ready,
    input logic [LENW-1:0] cmd_len,
    input logic            mbox_wr,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_rd_en,
    input logic            mem_wr_en,
    input logic            busy,
    input logic            boot_done,
    input logic            err_short,
    input logic            err_bad_cmd,
    input logic [CW-1:0]   credit_cnt,
    input logic [CW-1:0]   credit_dec
);

    localparam int RESP_BYTES = EXT_RESP ? 16 : 4;
    localparam logic [AW-1:0] LOW_REPLY = AW'(WIN_BYTES - RESP_BYTES);

    a_r1_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !busy && !boot_done && cmd_len >= LENW'(4)) |=> busy);

    a_r3_short_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !busy && !boot_done && cmd_len < LENW'(4)) |=> (err_short && !busy));

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(boot_done) |-> boot_done);

    a_r5_ignored_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && !busy && cmd_ready) |=> (!busy && !err_short));

    a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r11_reply_in_top: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr >= LOW_REPLY));

    a_r11_reply_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    a_r9_credit_changes_only_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(credit_cnt) || !$stable(credit_dec)) |-> ($past(mbox_wr) || $fell(busy)));

    a_r8_bad_keeps_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bad_cmd && !$past(mbox_wr)) |-> ($stable(credit_cnt) && $stable(credit_dec)));

endmodule

bind boot_cmd_seq boot_cmd_seq_chk #(
    .WIN_BYTES (WIN_BYTES),
    .EXT_RESP  (EXT_RESP),
    .CW        (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .cmd_len     (cmd_len),
    .mbox_wr     (mbox_wr),
    .mem_addr    (mem_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .busy        (busy),
    .boot_done   (boot_done),
    .err_short   (err_short),
    .err_bad_cmd (err_bad_cmd),
    .credit_cnt  (credit_cnt),
    .credit_dec  (credit_dec)
);

// File: tb/sim_boot_cmd_seq.sv
`timescale 1ns/1ps
// Bench: two sequencers (short and extended reply format) on their own RAM
// models, driven with the same frames; directed scenario tasks.
module sim_boot_cmd_seq;

    localparam int WIN  = 2048;
    localparam int AW   = 11;
    localparam int LENW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_ready = 1'b0;
    logic [LENW-1:0] cmd_len = '0;
    logic            mbox_wr = 1'b0;
    logic            ld_en = 1'b0;
    logic [AW-1:0]   ld_addr = '0;
    logic [7:0]      ld_data = '0;

    logic [AW-1:0] a0, a1;
    logic re0, re1, we0, we1;
    logic [7:0] rd0, rd1, wd0, wd1;
    logic busy0, busy1, done0, done1, es0, es1, eb0, eb1;
    logic [7:0] cc0, cc1, cd0, cd1;

    int n_chk = 0;
    int n_bad = 0;
    int n_es0 = 0;
    int n_eb0 = 0;

    always #2.5 clk = ~clk;

    boot_cmd_seq #(.WIN_BYTES(WIN), .EXT_RESP(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
        .mbox_wr(mbox_wr), .mem_addr(a0), .mem_rd_en(re0), .mem_rd_data(rd0),
        .mem_wr_en(we0), .mem_wr_data(wd0), .busy(busy0), .boot_done(done0),
        .err_short(es0), .err_bad_cmd(eb0), .credit_cnt(cc0), .credit_dec(cd0));

    boot_cmd_seq #(.WIN_BYTES(WIN), .EXT_RESP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
        .mbox_wr(mbox_wr), .mem_addr(a1), .mem_rd_en(re1), .mem_rd_data(rd1),
        .mem_wr_en(we1), .mem_wr_data(wd1), .busy(busy1), .boot_done(done1),
        .err_short(es1), .err_bad_cmd(eb1), .credit_cnt(cc1), .credit_dec(cd1));

    sim_ram #(.AW(AW)) u_ram0 (.clk(clk), .re(re0), .we(we0), .addr(a0), .wd(wd0), .rd(rd0),
                               .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data));
    sim_ram #(.AW(AW)) u_ram1 (.clk(clk), .re(re1), .we(we1), .addr(a1), .wd(wd1), .rd(rd1),
                               .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data));

    // Count one-cycle error pulses of the short-format unit.
    always @(negedge clk) begin
        if (es0) n_es0 = n_es0 + 1;
        if (eb0) n_eb0 = n_eb0 + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic put_byte(input int addr, input logic [7:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(addr); ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put_word(input int addr, input logic [31:0] w);
        for (int i = 0; i < 4; i++) put_byte(addr + i, w[i*8 +: 8]);
    endtask

    task automatic run_cmd(input int len, input bit expect_busy, input string req);
        @(negedge clk);
        cmd_len = LENW'(len); cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        check(req, {31'd0, busy0}, {31'd0, expect_busy});
        for (int i = 0; i < 200 && (busy0 || busy1); i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_mbox();
        @(negedge clk); mbox_wr = 1'b1;
        @(negedge clk); mbox_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 cnt", {24'd0, cc0}, 32'h0);
        check("R10 dec", {24'd0, cd0}, 32'hFF);
        check("R10 flags", {28'd0, busy0, done0, es0, eb0}, 32'h0);
    endtask

    task automatic t_ident();
        put_word(WIN - 4, 32'd8);
        run_cmd(4, 1'b1, "R1 busy on accept");
        check("R6 bytes", {u_ram0.mem[WIN-1], u_ram0.mem[WIN-2], u_ram0.mem[WIN-3], u_ram0.mem[WIN-4]}, 32'h1100_0044);
        check("R6 cnt/dec", {16'd0, cc0, cd0}, 32'h04FF);
        check("R1 busy low", {31'd0, busy0}, 32'h0);
        check("R7 w0", {u_ram1.mem[WIN-13], u_ram1.mem[WIN-14], u_ram1.mem[WIN-15], u_ram1.mem[WIN-16]}, 32'hFFFF_FFFF);
        check("R7 w1", {u_ram1.mem[WIN-9], u_ram1.mem[WIN-10], u_ram1.mem[WIN-11], u_ram1.mem[WIN-12]}, 32'h0000_000C);
        check("R7 w2", {u_ram1.mem[WIN-5], u_ram1.mem[WIN-6], u_ram1.mem[WIN-7], u_ram1.mem[WIN-8]}, 32'h1100_0044);
        check("R7 w3", {u_ram1.mem[WIN-1], u_ram1.mem[WIN-2], u_ram1.mem[WIN-3], u_ram1.mem[WIN-4]}, 32'h0000_0001);
        check("R7 cnt/dec", {16'd0, cc1, cd1}, 32'h10FF);
    endtask

    task automatic t_clear();
        pulse_mbox();
        @(negedge clk);
        check("R9 clear", {16'd0, cc0, cd0}, 32'h0000);
    endtask

    task automatic t_offset();
        // Frame of 8: code 8 at its lowest word, code 1 above it.
        put_word(WIN - 8, 32'd8);
        put_word(WIN - 4, 32'd1);
        run_cmd(8, 1'b1, "R1 busy len8");
        check("R2 offset cnt", {16'd0, cc0, cd0}, 32'h04FF);
        check("R2 not done", {31'd0, done0}, 32'h0);
    endtask

    task automatic t_bad();
        pulse_mbox();
        // Byte-swapped code 8 would be 0x08000000: unknown.
        put_word(WIN - 4, 32'h0800_0000);
        run_cmd(4, 1'b1, "R1 busy bad");
        check("R8 pulse", n_eb0, 1);
        check("R8 credit kept", {16'd0, cc0, cd0}, 32'h0000);
        check("R2 byte order bytes", {u_ram0.mem[WIN-1], u_ram0.mem[WIN-4]}, 32'h0800);
    endtask

    task automatic t_short();
        put_word(WIN - 4, 32'd8);
        pulse_mbox();
        run_cmd(3, 1'b0, "R3 no busy");
        check("R3 pulse", n_es0, 1);
        check("R3 credit kept", {16'd0, cc0, cd0}, 32'h0000);
        check("R3 no write", {u_ram0.mem[WIN-1], u_ram0.mem[WIN-4]}, 32'h0008);
    endtask

    task automatic t_nop();
        put_word(WIN - 4, 32'd5);
        put_word(WIN - 8, 32'hA5A5_A5A5);
        run_cmd(4, 1'b1, "R1 busy nop");
        check("R4 cnt/dec", {16'd0, cc0, cd0}, 32'h00FF);
        check("R4 no write", {u_ram0.mem[WIN-1], u_ram0.mem[WIN-2], u_ram0.mem[WIN-3], u_ram0.mem[WIN-4]}, 32'h0000_0005);
        pulse_mbox();
        put_word(WIN - 4, 32'd12);
        run_cmd(4, 1'b1, "R1 busy code12");
        check("R4 code12", {16'd0, cc0, cd0}, 32'h00FF);
    endtask

    task automatic t_finish();
        pulse_mbox();
        put_word(WIN - 4, 32'd1);
        run_cmd(4, 1'b1, "R1 busy finish");
        check("R5 done", {31'd0, done0}, 32'h1);
        check("R5 cnt/dec", {16'd0, cc0, cd0}, 32'h00FF);
        pulse_mbox();
        @(negedge clk);
        check("R9 ignored after done", {16'd0, cc0, cd0}, 32'h00FF);
        put_word(WIN - 4, 32'd8);
        run_cmd(4, 1'b0, "R5 ready ignored");
        check("R5 no reply", {u_ram0.mem[WIN-1], u_ram0.mem[WIN-4]}, 32'h0008);
        check("R5 still done", {24'd0, cc0, 7'd0, done0}, 32'h0001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_clear();
        t_offset();
        t_bad();
        t_short();
        t_nop();
        t_finish();
        finish_up();
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule

// Bench RAM model: one-cycle read latency, design write port and a
// bench preload port (design write wins).
module sim_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wd,
    output logic [7:0]    rd,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data
);
    logic [7:0] mem [0:(1<<AW)-1];

    always @(posedge clk) begin
        if (we)         mem[addr]    <= wd;
        else if (ld_en) mem[ld_addr] <= ld_data;
        if (re) rd <= mem[addr];
    end
endmodule